// File: doc/BRIEF.md
# Register-Programmed Byte SPI Master

This block is a software-driven SPI master that moves exactly one byte per operation. A processor reaches it through a small word-addressed register port with write and read strobes. On the serial side it drives a mode 0 link: the serial clock idles low, MOSI changes after falling edges and MISO is captured on rising edges, most significant bit first.

Sending and receiving are separate operations. Writing the transmit register launches an outgoing byte, and software polls a transmit-ready flag before writing the next one. Writing the receive-request register clocks eight bits in from MISO with MOSI held low, and a receive-ready flag signals that the byte can be collected. Chip select is a register bit of its own, so one select window can span any number of byte operations. No register that controls the link accepts a write until the unlock value has been written to the key register. The engine is held in reset while the run bit is zero.

Register map (word offsets on `bus_addr`): 0 key, 1 command (bit 0 = run), 2 transmit byte, 3 receive byte, 4 clock divide, 5 select (bit 0), 6 receive request, 7 status (bit 0 transmit-ready, bit 1 receive-ready, bit 2 busy, bit 3 unlocked). The key, transmit and receive-request offsets read as zero.

Top module: `spi_byte_master`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` and `mosi` are 0, the status word reads 0 (locked, run bit clear, nothing ready), and the command and divide registers read 0.
- R2: While the key register does not hold 0xAAAA, writes to the command, transmit, divide, select and receive-request offsets have no effect; writing any other value to the key locks the block again.
- R3: While the command run bit (bit 0) is 0 the engine is held in reset: a transfer in progress stops with `sclk` low within two cycles, busy and transmit-ready (status bits 2 and 0) read 0, receive-ready (status bit 1) is cleared, and transmit or receive-request writes start nothing.
- R4: An accepted transmit write shifts the byte out on `mosi`, most significant bit first, with exactly eight rising `sclk` edges; `mosi` never changes in the cycle `sclk` rises.
- R5: `sclk` idles low and, during a transfer, holds each level for divide+1 system clocks, giving a period of 2×(divide+1) system clocks.
- R6: Transmit-ready (status bit 0) is 1 only when the run bit is set and no byte is moving; a transmit write made while it is 0 is dropped.
- R7: A write to the receive-request offset (any data) clocks eight bits in from `miso`, sampled at rising `sclk` edges, while `mosi` stays 0; receive-ready (status bit 1) then goes to 1 and the receive offset returns the byte in bits 7:0.
- R8: A bus read of the receive offset clears receive-ready; reading any other offset does not.
- R9: Writing 1 to select bit 0 drives `cs_n` low and writing 0 drives it high; it stays low across consecutive byte operations.
- R10: A receive request made while a byte is still moving is dropped and starts no extra clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_rd | input | 1 | Register read strobe, one cycle per read |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
The checker assumes the bus strobes are single-cycle pulses that are never both high and that `miso` only settles between rising serial clock edges, as a mode 0 device would drive it. It also takes for granted that reset is held low from time zero for a few cycles. The directed bench drives every bus cycle from the falling system clock edge with one strobe at a time, and its device model changes `miso` only after each rising serial edge, so stimulus stays inside those assumptions. Halting the engine mid-byte and back-to-back writes are the only ways the bench disturbs a transfer, both through the normal register port.

// File: rtl/sbm_pkg.sv
// Package: shared constants and the register offset type for the byte SPI master.
// Assumes a 16-bit register port addressed by 3-bit word offsets.
package sbm_pkg;

    localparam int BUS_DW = 16;
    localparam int BUS_AW = 3;

    localparam logic [BUS_DW-1:0] UNLOCK_KEY = 16'hAAAA;

    typedef enum logic [BUS_AW-1:0] {
        REG_KEY   = 3'd0,
        REG_CMD   = 3'd1,
        REG_TXD   = 3'd2,
        REG_RXD   = 3'd3,
        REG_DIV   = 3'd4,
        REG_CSEL  = 3'd5,
        REG_RXREQ = 3'd6,
        REG_STAT  = 3'd7
    } sbm_reg_e;

    localparam int STAT_TXRDY = 0;
    localparam int STAT_RXRDY = 1;
    localparam int STAT_BUSY  = 2;
    localparam int STAT_UNLK  = 3;

endpackage

// File: rtl/sbm_clkdiv.sv
// Module: half-period tick generator for the serial clock.
// Emits a one-cycle tick every DIV+1 system clocks while enabled; the count
// restarts from zero whenever the enable drops. Assumes div is static during
// a transfer (software changes it only between bytes).
module sbm_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    // Half-period counter, cleared when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Tick marks the last cycle of each half period.
    always_comb begin
        tick = en && (cnt_q == div);
    end

endmodule

// File: rtl/sbm_shifter.sv
// Module: one-byte mode 0 shift engine.
// Starts on a single-cycle start pulse when idle. Each tick toggles the serial
// clock; rising edges sample miso, falling edges advance mosi. The byte ends on
// the falling edge after the last rising edge, with a registered done pulse.
// A low run input acts as a synchronous reset of the engine.
module sbm_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              start_tx,
    input  logic              start_rx,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic              done_rx,
    output logic [BYTE_W-1:0] rx_byte
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    logic              busy_q;
    logic              is_rx_q;
    logic              sclk_q;
    logic [CNT_W-1:0]  bitcnt_q;
    logic [BYTE_W-1:0] tx_sh_q;
    logic [BYTE_W-1:0] rx_sh_q;
    logic              done_q;
    logic              done_rx_q;

    // Transfer state machine: load, toggle clock on ticks, finish after last bit.
    always_ff @(posedge clk) begin
        done_q <= 1'b0;
        if (!rst_n || !run) begin
            busy_q    <= 1'b0;
            is_rx_q   <= 1'b0;
            sclk_q    <= 1'b0;
            bitcnt_q  <= '0;
            tx_sh_q   <= '0;
            rx_sh_q   <= '0;
            done_rx_q <= 1'b0;
        end else if (!busy_q) begin
            if (start_tx) begin
                busy_q   <= 1'b1;
                is_rx_q  <= 1'b0;
                bitcnt_q <= '0;
                tx_sh_q  <= tx_byte;
            end else if (start_rx) begin
                busy_q   <= 1'b1;
                is_rx_q  <= 1'b1;
                bitcnt_q <= '0;
                tx_sh_q  <= '0;
            end
        end else if (tick) begin
            if (!sclk_q) begin
                sclk_q   <= 1'b1;
                rx_sh_q  <= {rx_sh_q[BYTE_W-2:0], miso};
                bitcnt_q <= bitcnt_q + 1'b1;
            end else begin
                sclk_q  <= 1'b0;
                tx_sh_q <= {tx_sh_q[BYTE_W-2:0], 1'b0};
                if (bitcnt_q == LAST_BIT) begin
                    busy_q    <= 1'b0;
                    done_q    <= 1'b1;
                    done_rx_q <= is_rx_q;
                end
            end
        end
    end

    // Output mapping; mosi is forced low when idle.
    always_comb begin
        sclk    = sclk_q;
        mosi    = busy_q && tx_sh_q[BYTE_W-1];
        busy    = busy_q;
        done    = done_q;
        done_rx = done_rx_q;
        rx_byte = rx_sh_q;
    end

endmodule

// File: rtl/sbm_regfile.sv
// Module: register file and bus decode for the byte SPI master.
// Holds the key, run bit, divider, select bit, received byte and the ready
// flag. Gated writes take effect only while the key matches the unlock value.
// Assumes single-cycle bus strobes; read data is combinational.
module sbm_regfile
    import sbm_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic              done_rx,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              start_tx,
    output logic              start_rx,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              eng_run,
    output logic [DIV_W-1:0]  div,
    output logic              cs_on,
    output logic              unlocked,
    output logic              rx_ready
);

    localparam int RX_PAD  = BUS_DW - BYTE_W;
    localparam int DIV_PAD = BUS_DW - DIV_W;

    logic [BUS_DW-1:0] key_q;
    logic              run_q;
    logic [DIV_W-1:0]  div_q;
    logic              cs_q;
    logic [BYTE_W-1:0] rxd_q;
    logic              rxr_q;
    logic              wr_ok;
    logic              rd_rxd;
    logic              tx_rdy;

    // Write qualification and start pulses toward the engine.
    always_comb begin
        wr_ok    = bus_wr && (key_q == UNLOCK_KEY);
        tx_rdy   = run_q && !busy;
        start_tx = wr_ok && (bus_addr == REG_TXD) && tx_rdy;
        start_rx = wr_ok && (bus_addr == REG_RXREQ) && tx_rdy;
        tx_byte  = bus_wdata[BYTE_W-1:0];
        rd_rxd   = bus_rd && (bus_addr == REG_RXD);
    end

    // Key register, always writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0;
        end else if (bus_wr && bus_addr == REG_KEY) begin
            key_q <= bus_wdata;
        end
    end

    // Gated control registers: run bit, divider, select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            div_q <= '0;
            cs_q  <= 1'b0;
        end else if (wr_ok) begin
            if (bus_addr == REG_CMD)  run_q <= bus_wdata[0];
            if (bus_addr == REG_DIV)  div_q <= bus_wdata[DIV_W-1:0];
            if (bus_addr == REG_CSEL) cs_q  <= bus_wdata[0];
        end
    end

    // Received byte and its ready flag; a completing byte wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_q) begin
            rxd_q <= rst_n ? rxd_q : '0;
            rxr_q <= 1'b0;
        end else if (done && done_rx) begin
            rxd_q <= rx_byte;
            rxr_q <= 1'b1;
        end else if (rd_rxd) begin
            rxr_q <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CMD:  bus_rdata = {{(BUS_DW-1){1'b0}}, run_q};
            REG_RXD:  bus_rdata = {{RX_PAD{1'b0}}, rxd_q};
            REG_DIV:  bus_rdata = {{DIV_PAD{1'b0}}, div_q};
            REG_CSEL: bus_rdata = {{(BUS_DW-1){1'b0}}, cs_q};
            REG_STAT: begin
                bus_rdata[STAT_TXRDY] = tx_rdy;
                bus_rdata[STAT_RXRDY] = rxr_q;
                bus_rdata[STAT_BUSY]  = busy;
                bus_rdata[STAT_UNLK]  = (key_q == UNLOCK_KEY);
            end
            default:  bus_rdata = '0;
        endcase
    end

    // Outputs toward the engine and the pins.
    always_comb begin
        eng_run  = run_q;
        div      = div_q;
        cs_on    = cs_q;
        unlocked = (key_q == UNLOCK_KEY);
        rx_ready = rxr_q;
    end

endmodule

// File: rtl/spi_byte_master.sv
// Module: top of the register-programmed byte SPI master.
// Connects the register file, the serial clock divider and the shift engine.
// Assumes a mode 0 device on the serial side and single-cycle bus strobes.
module spi_byte_master
    import sbm_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);

    logic              busy;
    logic              done;
    logic              done_rx;
    logic [BYTE_W-1:0] rx_byte;
    logic              start_tx;
    logic              start_rx;
    logic [BYTE_W-1:0] tx_byte;
    logic              eng_run;
    logic [DIV_W-1:0]  div;
    logic              cs_on;
    logic              unlocked;
    logic              rx_ready;
    logic              tick;
    logic              cs_n_q;

    sbm_regfile #(.BYTE_W(BYTE_W), .DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .done      (done),
        .done_rx   (done_rx),
        .rx_byte   (rx_byte),
        .start_tx  (start_tx),
        .start_rx  (start_rx),
        .tx_byte   (tx_byte),
        .eng_run   (eng_run),
        .div       (div),
        .cs_on     (cs_on),
        .unlocked  (unlocked),
        .rx_ready  (rx_ready)
    );

    sbm_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (busy),
        .div   (div),
        .tick  (tick)
    );

    sbm_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (eng_run),
        .tick     (tick),
        .start_tx (start_tx),
        .start_rx (start_rx),
        .tx_byte  (tx_byte),
        .miso     (miso),
        .sclk     (sclk),
        .mosi     (mosi),
        .busy     (busy),
        .done     (done),
        .done_rx  (done_rx),
        .rx_byte  (rx_byte)
    );

    // Chip select follows the select register, inverted for the active-low pin.
    always_comb begin
        cs_n_q = !cs_on;
        cs_n   = cs_n_q;
    end

endmodule

// File: rtl/sbm_checker.sv
// Module: temporal checks on the byte SPI master, bound to the top.
// Assumes reset is low from time zero and bus strobes are single-cycle.
module sbm_checker
    import sbm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic              sclk,
    input logic              cs_n,
    input logic              mosi,
    input logic              busy,
    input logic              eng_run,
    input logic              unlocked,
    input logic              rx_ready
);

    // R2: a locked select write leaves the pin alone.
    a_r2_locked_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && bus_wr && bus_addr == REG_CSEL) |=> $stable(cs_n));

    // R3: a cleared run bit stops the clock and the engine.
    a_r3_halt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_run |=> (!sclk && !busy));

    // R4: data never moves as the clock rises.
    a_r4_mosi_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));

    // R5: serial clock is low whenever no byte is moving.
    a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    // R7: the ready flag only appears once the engine is idle.
    a_r7_rx_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> !busy);

    // R8: reading the receive byte with nothing completing clears the flag.
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == REG_RXD && !busy && !$past(busy)) |=> !rx_ready);

    // R9: an unlocked select write sets the pin to the written level.
    a_r9_cs_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && bus_wr && bus_addr == REG_CSEL) |=> (cs_n == !$past(bus_wdata[0])));

endmodule

bind spi_byte_master sbm_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .busy      (busy),
    .eng_run   (eng_run),
    .unlocked  (unlocked),
    .rx_ready  (rx_ready)
);

// File: tb/spi_byte_master_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, a mode 0 device model on the pins.
module spi_byte_master_bench;

    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sclk;
    logic        cs_n;
    logic        mosi;
    logic        miso;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Device model state: updated only in the sclk process.
    int          rise_n = 0;
    logic [7:0]  cap = '0;
    time         t_last = 0;
    time         t_prev = 0;
    int          base = 0;
    logic [7:0]  sbyte = '0;

    always #(CLK_NS/2) clk = ~clk;

    spi_byte_master u_spi_byte_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .miso      (miso)
    );

    // Capture mosi and time each rising serial edge.
    always @(posedge sclk) begin
        cap    <= {cap[6:0], mosi};
        rise_n <= rise_n + 1;
        t_prev <= t_last;
        t_last <= $time;
    end

    // Device drives the next bit after every rising edge.
    always_comb begin
        int idx;
        idx  = rise_n - base;
        miso = (idx >= 0 && idx < 8) ? sbyte[7 - idx] : 1'b0;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 4000; i++) begin
            rd(3'd7, s);
            if (!s[2]) return;
        end
        chk("wait_idle", 32'd1, 32'd0);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R1 cs_n", cs_n, 1);
        chk("R1 sclk", sclk, 0);
        chk("R1 mosi", mosi, 0);
        rd(3'd7, d); chk("R1 status", d, 0);
        rd(3'd1, d); chk("R1 cmd", d, 0);
        rd(3'd4, d); chk("R1 div", d, 0);
    endtask

    task automatic t_lock();
        logic [15:0] d;
        int r0;
        r0 = rise_n;
        wr(3'd5, 16'h0001); chk("R2 locked select", cs_n, 1);
        wr(3'd1, 16'h0001); rd(3'd1, d); chk("R2 locked cmd", d, 0);
        wr(3'd4, 16'h0005); rd(3'd4, d); chk("R2 locked div", d, 0);
        wr(3'd2, 16'h00FF); repeat (10) @(negedge clk);
        chk("R2 locked tx edges", rise_n - r0, 0);
        wr(3'd0, 16'hAAAA); rd(3'd7, d); chk("R2 unlocked flag", d[3], 1);
    endtask

    task automatic t_tx();
        logic [15:0] d;
        int r0;
        wr(3'd1, 16'h0001);
        rd(3'd7, d); chk("R6 ready when idle", d[0], 1);
        wr(3'd4, 16'h0002);
        wr(3'd5, 16'h0001); chk("R9 select low", cs_n, 0);
        r0 = rise_n;
        wr(3'd2, 16'h00A5);
        wait_idle();
        chk("R4 byte A5", cap, 8'hA5);
        chk("R4 edge count", rise_n - r0, 8);
        chk("R5 period div2", 32'(t_last - t_prev), 32'(2 * 3 * CLK_NS));
        chk("R5 sclk idle", sclk, 0);
        wr(3'd4, 16'h0000);
        r0 = rise_n;
        wr(3'd2, 16'h003C);
        wait_idle();
        chk("R4 byte 3C", cap, 8'h3C);
        chk("R5 period div0", 32'(t_last - t_prev), 32'(2 * CLK_NS));
        chk("R9 select held", cs_n, 0);
        wr(3'd5, 16'h0000); chk("R9 select released", cs_n, 1);
    endtask

    task automatic t_drop();
        logic [15:0] d;
        int r0;
        wr(3'd4, 16'h0003);
        r0 = rise_n;
        wr(3'd2, 16'h0081);
        wr(3'd2, 16'h00FF);
        rd(3'd7, d); chk("R6 not ready while busy", d[0], 0);
        wait_idle();
        chk("R6 second byte dropped", cap, 8'h81);
        chk("R6 edge count", rise_n - r0, 8);
    endtask

    task automatic t_rx();
        logic [15:0] d;
        int r0;
        wr(3'd4, 16'h0001);
        sbyte = 8'hC3;
        base  = rise_n;
        r0    = rise_n;
        wr(3'd6, 16'h0000);
        wr(3'd6, 16'h0000);
        wait_idle();
        chk("R10 extra request dropped", rise_n - r0, 8);
        chk("R7 mosi low", cap, 8'h00);
        rd(3'd7, d); chk("R8 status read keeps ready", d[1], 1);
        rd(3'd7, d); chk("R7 ready set", d[1], 1);
        rd(3'd3, d); chk("R7 byte C3", d, 16'h00C3);
        rd(3'd7, d); chk("R8 ready cleared", d[1], 0);
    endtask

    task automatic t_halt();
        logic [15:0] d;
        int r0;
        wr(3'd4, 16'h0007);
        wr(3'd2, 16'h00F0);
        repeat (20) @(negedge clk);
        wr(3'd1, 16'h0000);
        @(negedge clk);
        chk("R3 sclk stopped", sclk, 0);
        rd(3'd7, d); chk("R3 status held", d[2:0], 3'b000);
        r0 = rise_n;
        wr(3'd2, 16'h00AA); repeat (20) @(negedge clk);
        chk("R3 held start ignored", rise_n - r0, 0);
        wr(3'd1, 16'h0001);
        rd(3'd7, d); chk("R3 released ready", d[0], 1);
        wr(3'd4, 16'h0000);
        sbyte = 8'h5E;
        base  = rise_n;
        wr(3'd6, 16'h0000);
        wait_idle();
        rd(3'd7, d); chk("R7 ready before halt", d[1], 1);
        wr(3'd1, 16'h0000);
        wr(3'd1, 16'h0001);
        rd(3'd7, d); chk("R3 halt clears ready", d[1], 0);
    endtask

    task automatic t_relock();
        logic [15:0] d;
        int r0;
        wr(3'd0, 16'h1234);
        rd(3'd7, d); chk("R2 relocked", d[3], 0);
        wr(3'd5, 16'h0001); chk("R2 relocked select", cs_n, 1);
        r0 = rise_n;
        wr(3'd2, 16'h0055); repeat (10) @(negedge clk);
        chk("R2 relocked tx", rise_n - r0, 0);
        wr(3'd0, 16'hAAAA);
        rd(3'd7, d); chk("R2 unlocked again", d[3], 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lock();
        t_tx();
        t_drop();
        t_rx();
        t_halt();
        t_relock();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_NS * 150000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule